// File: doc/BRIEF.md
# Packet Buffer Memory Manager

This block hands out and takes back pages of a shared packet buffer in a network controller. A host writes a command, made of a 3-bit opcode and a 3-bit page-count argument N. An allocate command claims N+1 free pages and gives them to the lowest free packet number. A specific-packet release gives back every page that one packet owns. A head-of-receive release does the same for the packet at the head of the receive queue. The block also holds the queue of packet numbers waiting to be transmitted and the queue of packet numbers whose transmission has finished.

A command takes effect on its trailing edge. That is the first clock in which the write strobe is seen low after being high. An allocation resolves in that same cycle and pulses an interrupt. A release walks the page table, one page per clock, behind a BUSY flag. Free pages are tracked in a bitmap, and each page records the packet number that owns it. A second release sent while BUSY is high is dropped, and a sticky error flag records it. Clearing the transmit queues discards the packet numbers in them and frees no pages.

Top module: `pbuf_mgr`

## Requirements
- R1: A command is taken from the opcode and argument present on the last cycle `cmd_wr` is high. It acts on the first rising edge at which `cmd_wr` is low. `busy` and `alloc_failed` do not change while `cmd_wr` is still high.
- R2: Allocate (opcode 001) with argument N and enough resources marks the N+1 lowest-numbered free pages as owned by the lowest unused packet number. In the cycle after the trailing edge, `alloc_pkt` shows that number, `alloc_failed` is low, and `alloc_irq` is high for exactly one cycle.
- R3: An allocate fails when fewer than N+1 pages are free or no packet number is unused. It then takes no page, drives `alloc_failed` high and pulses `alloc_irq`, and `alloc_pkt` keeps its previous value.
- R4: Specific-packet release (opcode 101) frees every page owned by the packet number held in the packet number register when the command issued, and then frees that packet number. `busy` stays high for exactly NUM_PAGES cycles. Writing the packet number register during that time does not change what is freed.
- R5: Head-of-receive release (opcode 100) pops the head of the receive queue and frees that packet's pages and number, with the same `busy` timing as R4.
- R6: Opcode 011 pops the head of the receive queue, frees no pages, and leaves `busy` low.
- R7: Opcode 110 appends the packet number register to the transmit queue. `tx_head` presents entries oldest first, and `tx_pop` advances it.
- R8: Opcode 111 empties the transmit queue and the completion queue and leaves `free_pages` unchanged. Until then, completion entries are read oldest first on `cpl_head`.
- R9: Every opcode other than 001 ignores the argument N.
- R10: A release (opcode 100 or 101) issued while `busy` is high does nothing and sets `seq_err`. `seq_err` stays high until reset or opcode 010.
- R11: Opcode 010 frees all pages and packet numbers, empties all three queues, and clears `busy`, `alloc_failed` and `seq_err`. The state after `rst_n` is the same.
- R12: Opcode 000 changes no state and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe; the command acts on its trailing edge |
| cmd_op | input | 3 | Opcode |
| cmd_arg | input | 3 | Page-count argument N (allocate only) |
| pnr_wr | input | 1 | Packet number register write strobe |
| pnr_din | input | PW | Packet number register write data |
| rx_push | input | 1 | Append a received packet number |
| rx_pkt | input | PW | Received packet number |
| rx_empty | output | 1 | Receive queue empty |
| tx_pop | input | 1 | Remove the head of the transmit queue |
| tx_head | output | PW | Oldest queued transmit packet number |
| tx_empty | output | 1 | Transmit queue empty |
| cpl_push | input | 1 | Append a completed packet number |
| cpl_pkt | input | PW | Completed packet number |
| cpl_pop | input | 1 | Remove the head of the completion queue |
| cpl_head | output | PW | Oldest completion entry |
| cpl_empty | output | 1 | Completion queue empty |
| busy | output | 1 | A release is in progress |
| alloc_failed | output | 1 | Last allocation failed |
| alloc_pkt | output | PW | Packet number from the last successful allocation |
| alloc_irq | output | 1 | One-cycle pulse when an allocation resolves |
| seq_err | output | 1 | Sticky: a release was issued while busy |
| free_pages | output | CW | Number of free pages |

## Verification
The bench builds the block with 8 pages, 8 packet numbers and queues 4 deep. With only 8 pages, a single allocate with N=7 takes the whole buffer, so both failure cases come up in a few commands. A release then lasts 8 cycles, which leaves room to rewrite the packet number register and to issue a second release while the first is still running. The small page count also keeps every count of free pages easy to work out by hand.

// File: rtl/pbuf_pkg.sv
// Package: shared opcode encoding for the packet buffer memory manager.
// Assumes a 3-bit opcode field.
package pbuf_pkg;
    typedef enum logic [2:0] {
        OP_NOP     = 3'b000,
        OP_ALLOC   = 3'b001,
        OP_RESET   = 3'b010,
        OP_RXDROP  = 3'b011,
        OP_RXFREE  = 3'b100,
        OP_FREEPKT = 3'b101,
        OP_TXPUSH  = 3'b110,
        OP_QCLEAR  = 3'b111
    } op_e;
endpackage

// File: rtl/pkt_fifo.sv
// pkt_fifo: small synchronous queue of packet numbers.
// A flush takes priority over push and pop. A push to a full queue is dropped
// unless a pop happens in the same cycle. A pop from an empty queue is ignored.
// Assumes DEPTH >= 2.
module pkt_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int NW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [NW-1:0] count;
    logic          do_push, do_pop;

    // Qualify push and pop against the current fill level.
    always_comb begin
        do_pop  = pop && (count != '0);
        do_push = push && ((count != NW'(DEPTH)) || do_pop);
    end

    // Advance the pointers and the fill count; a flush empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
        end
    end

    // Storage write; the queue contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= din;
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);
endmodule

// File: rtl/page_pool.sv
// page_pool: free-page bitmap, page-owner table and packet-number usage map.
// An allocation resolves in one cycle: it takes the N+1 lowest free pages and
// the lowest unused packet number. A release walks the pages one per cycle for
// NUM_PAGES cycles with busy high, freeing the pages owned by the captured
// target, and frees the target number on its last step.
// Assumes the caller never starts a release while busy, and that
// NUM_PAGES >= 2 and NUM_PKTS >= 2.
module page_pool #(
    parameter int NUM_PAGES = 32,
    parameter int NUM_PKTS  = 32,
    localparam int PW = $clog2(NUM_PKTS),
    localparam int CW = $clog2(NUM_PAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_all,
    input  logic          alloc_go,
    input  logic [2:0]    alloc_n,
    input  logic          rel_go,
    input  logic [PW-1:0] rel_pkt,
    output logic          busy,
    output logic          alloc_done,
    output logic          alloc_fail,
    output logic [PW-1:0] alloc_pkt,
    output logic [CW-1:0] free_cnt
);
    localparam int IW = $clog2(NUM_PAGES);
    localparam int TW = (CW > 4) ? CW : 4;

    logic [NUM_PAGES-1:0] free_map;
    logic [PW-1:0]        owner [NUM_PAGES];
    logic [NUM_PKTS-1:0]  pkt_used;
    logic [IW-1:0]        scan;
    logic [PW-1:0]        target;

    logic [NUM_PAGES-1:0] grab;
    logic [TW:0]          taken, need;
    logic [PW-1:0]        pick;
    logic                 pfound, alloc_ok;

    // Choose the N+1 lowest free pages through a running-count chain.
    always_comb begin
        need  = (TW + 1)'(alloc_n) + 1'b1;
        taken = '0;
        grab  = '0;
        for (int p = 0; p < NUM_PAGES; p++) begin
            if (free_map[p] && (taken < need)) begin
                grab[p] = 1'b1;
                taken   = taken + 1'b1;
            end
        end
    end

    // Find the lowest unused packet number.
    always_comb begin
        pfound = 1'b0;
        pick   = '0;
        for (int q = NUM_PKTS - 1; q >= 0; q--) begin
            if (!pkt_used[q]) begin
                pfound = 1'b1;
                pick   = PW'(q);
            end
        end
        alloc_ok = pfound && (taken == need);
    end

    // Count free pages for the status output.
    always_comb begin
        free_cnt = '0;
        for (int p = 0; p < NUM_PAGES; p++) begin
            free_cnt = free_cnt + CW'(free_map[p]);
        end
    end

    // Page ownership state: the release walk first, then the allocation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            free_map   <= '1;
            pkt_used   <= '0;
            busy       <= 1'b0;
            scan       <= '0;
            target     <= '0;
            alloc_done <= 1'b0;
            alloc_fail <= 1'b0;
            alloc_pkt  <= '0;
        end else begin
            alloc_done <= 1'b0;
            if (rel_go) begin
                busy   <= 1'b1;
                scan   <= '0;
                target <= rel_pkt;
            end else if (busy) begin
                if (!free_map[scan] && (owner[scan] == target)) begin
                    free_map[scan] <= 1'b1;
                end
                if (scan == IW'(NUM_PAGES - 1)) begin
                    busy             <= 1'b0;
                    pkt_used[target] <= 1'b0;
                end else begin
                    scan <= scan + 1'b1;
                end
            end
            if (alloc_go) begin
                alloc_done <= 1'b1;
                alloc_fail <= !alloc_ok;
                if (alloc_ok) begin
                    alloc_pkt      <= pick;
                    pkt_used[pick] <= 1'b1;
                    for (int p = 0; p < NUM_PAGES; p++) begin
                        if (grab[p]) begin
                            free_map[p] <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    // Owner table write on allocation; entries of free pages are don't-care.
    always_ff @(posedge clk) begin
        if (alloc_go && alloc_ok && rst_n && !clear_all) begin
            for (int p = 0; p < NUM_PAGES; p++) begin
                if (grab[p]) begin
                    owner[p] <= pick;
                end
            end
        end
    end
endmodule

// File: rtl/pbuf_mgr.sv
// pbuf_mgr: command-driven memory manager for a shared packet buffer.
// Decodes a command on the trailing edge of cmd_wr, drives the page pool and
// owns the receive, transmit and completion queues of packet numbers.
// Assumes a command strobe lasts at least one cycle and is followed by at
// least one low cycle.
module pbuf_mgr
    import pbuf_pkg::*;
#(
    parameter int NUM_PAGES = 32,
    parameter int NUM_PKTS  = 32,
    parameter int QDEPTH    = 32,
    localparam int PW = $clog2(NUM_PKTS),
    localparam int CW = $clog2(NUM_PAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [2:0]    cmd_op,
    input  logic [2:0]    cmd_arg,
    input  logic          pnr_wr,
    input  logic [PW-1:0] pnr_din,
    input  logic          rx_push,
    input  logic [PW-1:0] rx_pkt,
    output logic          rx_empty,
    input  logic          tx_pop,
    output logic [PW-1:0] tx_head,
    output logic          tx_empty,
    input  logic          cpl_push,
    input  logic [PW-1:0] cpl_pkt,
    input  logic          cpl_pop,
    output logic [PW-1:0] cpl_head,
    output logic          cpl_empty,
    output logic          busy,
    output logic          alloc_failed,
    output logic [PW-1:0] alloc_pkt,
    output logic          alloc_irq,
    output logic          seq_err,
    output logic [CW-1:0] free_pages
);
    logic          cmd_q;
    op_e           op_q;
    logic [2:0]    arg_q;
    logic [PW-1:0] pnr;
    logic [PW-1:0] rx_head;
    logic          issue, is_rel, rel_go, clear_all, alloc_go;
    logic          rx_pop, tx_push, q_clear;
    logic [PW-1:0] rel_pkt;

    // Hold the command from the last cycle of the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= 1'b0;
            op_q  <= OP_NOP;
            arg_q <= '0;
        end else begin
            cmd_q <= cmd_wr;
            if (cmd_wr) begin
                op_q  <= op_e'(cmd_op);
                arg_q <= cmd_arg;
            end
        end
    end

    // Packet number register written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pnr <= '0;
        end else if (pnr_wr) begin
            pnr <= pnr_din;
        end
    end

    // Decode the issued command into strobes for the pool and the queues.
    always_comb begin
        issue     = cmd_q && !cmd_wr;
        is_rel    = issue && ((op_q == OP_RXFREE) || (op_q == OP_FREEPKT));
        rel_go    = is_rel && !busy && ((op_q == OP_FREEPKT) || !rx_empty);
        rel_pkt   = (op_q == OP_RXFREE) ? rx_head : pnr;
        clear_all = issue && (op_q == OP_RESET);
        alloc_go  = issue && (op_q == OP_ALLOC);
        rx_pop    = (issue && (op_q == OP_RXDROP)) || (rel_go && (op_q == OP_RXFREE));
        tx_push   = issue && (op_q == OP_TXPUSH);
        q_clear   = issue && ((op_q == OP_QCLEAR) || (op_q == OP_RESET));
    end

    // Sticky flag for a release issued while busy.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            seq_err <= 1'b0;
        end else if (is_rel && busy) begin
            seq_err <= 1'b1;
        end
    end

    page_pool #(.NUM_PAGES(NUM_PAGES), .NUM_PKTS(NUM_PKTS)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_all  (clear_all),
        .alloc_go   (alloc_go),
        .alloc_n    (arg_q),
        .rel_go     (rel_go),
        .rel_pkt    (rel_pkt),
        .busy       (busy),
        .alloc_done (alloc_irq),
        .alloc_fail (alloc_failed),
        .alloc_pkt  (alloc_pkt),
        .free_cnt   (free_pages)
    );

    pkt_fifo #(.W(PW), .DEPTH(QDEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (clear_all),
        .push  (rx_push),
        .din   (rx_pkt),
        .pop   (rx_pop),
        .dout  (rx_head),
        .empty (rx_empty)
    );

    pkt_fifo #(.W(PW), .DEPTH(QDEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (q_clear),
        .push  (tx_push),
        .din   (pnr),
        .pop   (tx_pop),
        .dout  (tx_head),
        .empty (tx_empty)
    );

    pkt_fifo #(.W(PW), .DEPTH(QDEPTH)) u_cplq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (q_clear),
        .push  (cpl_push),
        .din   (cpl_pkt),
        .pop   (cpl_pop),
        .dout  (cpl_head),
        .empty (cpl_empty)
    );
endmodule

// File: rtl/pbuf_mgr_chk.sv
// pbuf_mgr_chk: temporal properties of pbuf_mgr, attached by bind.
// Watches the ports plus the decoded issue strobe and the held opcode.
module pbuf_mgr_chk #(
    parameter int NUM_PAGES = 32,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_wr,
    input logic          issue,
    input logic [2:0]    op_q,
    input logic          busy,
    input logic          alloc_irq,
    input logic          seq_err,
    input logic          tx_empty,
    input logic          cpl_empty,
    input logic [CW-1:0] free_pages
);
    int unsigned run;

    // Count the cycles of busy already seen in the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 0;
        end else begin
            run <= busy ? run + 1 : 0;
        end
    end

    assert_busy_trailing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!$past(cmd_wr) && $past(cmd_wr, 2)));

    assert_irq_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_irq |=> !alloc_irq);

    assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run < NUM_PAGES));

    assert_qclear_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (op_q == 3'b111)) |=> (tx_empty && cpl_empty));

    assert_qclear_pages_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (op_q == 3'b111) && !busy) |=> $stable(free_pages));

    assert_seqerr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_err) |-> $past(issue && (op_q == 3'b010)));

    assert_reset_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (op_q == 3'b010)) |=> (!busy && (free_pages == CW'(NUM_PAGES))));

    assert_nop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (op_q == 3'b000) && !busy) |=> ($stable(free_pages) && !alloc_irq));
endmodule

bind pbuf_mgr pbuf_mgr_chk #(.NUM_PAGES(NUM_PAGES), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .issue      (issue),
    .op_q       (op_q),
    .busy       (busy),
    .alloc_irq  (alloc_irq),
    .seq_err    (seq_err),
    .tx_empty   (tx_empty),
    .cpl_empty  (cpl_empty),
    .free_pages (free_pages)
);

// File: tb/sim_pbuf_mgr.sv
module sim_pbuf_mgr;
    localparam int NP = 8;
    localparam int NK = 8;
    localparam int QD = 4;
    localparam int PW = 3;
    localparam int CW = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0, pnr_wr = 1'b0, rx_push = 1'b0;
    logic          tx_pop = 1'b0, cpl_push = 1'b0, cpl_pop = 1'b0;
    logic [2:0]    cmd_op = '0, cmd_arg = '0;
    logic [PW-1:0] pnr_din = '0, rx_pkt = '0, cpl_pkt = '0;
    logic          rx_empty, tx_empty, cpl_empty, busy, alloc_failed, alloc_irq, seq_err;
    logic [PW-1:0] tx_head, cpl_head, alloc_pkt;
    logic [CW-1:0] free_pages;

    pbuf_mgr #(.NUM_PAGES(NP), .NUM_PKTS(NK), .QDEPTH(QD)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .pnr_wr(pnr_wr), .pnr_din(pnr_din), .rx_push(rx_push), .rx_pkt(rx_pkt),
        .rx_empty(rx_empty), .tx_pop(tx_pop), .tx_head(tx_head), .tx_empty(tx_empty),
        .cpl_push(cpl_push), .cpl_pkt(cpl_pkt), .cpl_pop(cpl_pop), .cpl_head(cpl_head),
        .cpl_empty(cpl_empty), .busy(busy), .alloc_failed(alloc_failed),
        .alloc_pkt(alloc_pkt), .alloc_irq(alloc_irq), .seq_err(seq_err),
        .free_pages(free_pages)
    );

    int checks = 0;
    int errors = 0;
    int brun = 0;
    int blast = 0;
    logic [3:0] exp_q[$];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare each allocation result with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && alloc_irq) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2/R12 unexpected alloc_irq actual=1 expected=0");
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                check("R2/R3 alloc {failed,pkt}", int'({alloc_failed, alloc_pkt}), int'(e));
            end
        end
    end

    // Monitor: length of the latest busy run.
    always @(negedge clk) begin
        if (busy) begin
            brun++;
        end else if (brun != 0) begin
            blast = brun;
            brun  = 0;
        end
    end

    task automatic issue(input logic [2:0] op, input logic [2:0] n);
        logic b0, f0;
        @(negedge clk);
        b0 = busy;
        f0 = alloc_failed;
        cmd_op = op; cmd_arg = n; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        check("R1 busy before trailing edge", int'(busy), int'(b0));
        check("R1 failed before trailing edge", int'(alloc_failed), int'(f0));
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic [2:0] n, input logic fail, input logic [PW-1:0] pkt);
        exp_q.push_back({fail, pkt});
        issue(3'b001, n);
    endtask

    task automatic set_pnr(input logic [PW-1:0] v);
        @(negedge clk); pnr_wr = 1'b1; pnr_din = v;
        @(negedge clk); pnr_wr = 1'b0;
    endtask

    task automatic push_rx(input logic [PW-1:0] v);
        @(negedge clk); rx_push = 1'b1; rx_pkt = v;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic push_cpl(input logic [PW-1:0] v);
        @(negedge clk); cpl_push = 1'b1; cpl_pkt = v;
        @(negedge clk); cpl_push = 1'b0;
    endtask

    task automatic pulse_tx_pop();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic pulse_cpl_pop();
        @(negedge clk); cpl_pop = 1'b1;
        @(negedge clk); cpl_pop = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: state after reset
        check("R11 reset busy", int'(busy), 0);
        check("R11 reset failed", int'(alloc_failed), 0);
        check("R11 reset seq_err", int'(seq_err), 0);
        check("R11 reset free_pages", int'(free_pages), NP);
        check("R11 reset queues empty", int'({rx_empty, tx_empty, cpl_empty}), 7);

        // R2: successful allocations
        do_alloc(3'd2, 1'b0, 3'd0);
        check("R2 free after 3 pages", int'(free_pages), 5);
        do_alloc(3'd1, 1'b0, 3'd1);
        check("R2 free after 2 pages", int'(free_pages), 3);
        // R3: too few pages
        do_alloc(3'd3, 1'b1, 3'd1);
        check("R3 failed high", int'(alloc_failed), 1);
        check("R3 no pages taken", int'(free_pages), 3);

        // R12: no-op with a nonzero argument
        issue(3'b000, 3'd5);
        check("R12 nop keeps failed", int'(alloc_failed), 1);
        check("R12 nop keeps free_pages", int'(free_pages), 3);

        // R7, R9: transmit queue order, argument ignored
        set_pnr(3'd1);
        issue(3'b110, 3'd7);
        check("R7 tx head first", int'(tx_head), 1);
        check("R9 enqueue ignores N", int'(free_pages), 3);
        set_pnr(3'd0);
        issue(3'b110, 3'd0);
        check("R7 head unchanged by second push", int'(tx_head), 1);
        pulse_tx_pop();
        check("R7 tx head second", int'(tx_head), 0);
        pulse_tx_pop();
        check("R7 tx empty", int'(tx_empty), 1);

        // R4, R10: specific release, pnr rewrite and second release while busy
        issue(3'b101, 3'd6);
        check("R4 busy after trailing edge", int'(busy), 1);
        set_pnr(3'd1);
        issue(3'b101, 3'd0);
        check("R10 seq_err set", int'(seq_err), 1);
        wait_idle();
        check("R4 busy length", blast, NP);
        check("R4 captured pnr freed only pkt 0", int'(free_pages), 6);
        check("R10 seq_err sticky", int'(seq_err), 1);

        // R6: drop the receive head without freeing
        push_rx(3'd1);
        check("R6 rx nonempty", int'(rx_empty), 0);
        issue(3'b011, 3'd5);
        check("R6 busy stays low", int'(busy), 0);
        check("R6 rx popped", int'(rx_empty), 1);
        check("R6 no pages freed", int'(free_pages), 6);

        // R5: release from the receive head
        push_rx(3'd1);
        issue(3'b100, 3'd2);
        check("R5 busy high", int'(busy), 1);
        check("R5 rx popped", int'(rx_empty), 1);
        wait_idle();
        check("R5 busy length", blast, NP);
        check("R5 pages freed", int'(free_pages), NP);

        // R2, R3: whole buffer, then nothing left
        do_alloc(3'd7, 1'b0, 3'd0);
        check("R2 all pages taken", int'(free_pages), 0);
        do_alloc(3'd0, 1'b1, 3'd0);
        check("R3 empty pool fails", int'(alloc_failed), 1);

        // R8: completion read order, then queue clear
        issue(3'b110, 3'd0);
        push_cpl(3'd3);
        push_cpl(3'd5);
        check("R8 cpl head first", int'(cpl_head), 3);
        pulse_cpl_pop();
        check("R8 cpl head second", int'(cpl_head), 5);
        push_cpl(3'd6);
        issue(3'b111, 3'd4);
        check("R8 tx cleared", int'(tx_empty), 1);
        check("R8 cpl cleared", int'(cpl_empty), 1);
        check("R8 no pages freed", int'(free_pages), 0);

        // R11: reset-all command
        issue(3'b010, 3'd3);
        check("R11 cmd free_pages", int'(free_pages), NP);
        check("R11 cmd seq_err", int'(seq_err), 0);
        check("R11 cmd failed", int'(alloc_failed), 0);
        check("R11 cmd busy", int'(busy), 0);
        do_alloc(3'd0, 1'b0, 3'd0);
        check("R11 packet numbers freed", int'(free_pages), NP - 1);

        repeat (3) @(negedge clk);
        check("R2 every allocation interrupted", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule